// File: doc/BRIEF.md
# Clock Source Select, Divide and Gate Control Slice

This block is the control state for one node of a clock tree. That node is either an intermediate integer divider or a base clock output. It keeps one 32-bit control word with three fields. The first is a source selector. The second is an optional integer divide field. The third is an active-high disable bit. A simple write strobe loads the word. The current word is always visible on a read bus. Real clock waveforms are generated elsewhere. Here each of the 17 candidate sources appears only as a pair of indications: it exists (valid) and it is running (enabled).

Each instance is set by parameters. One parameter is a sparse mask of the source codes the node may pick. Another is the width of its divide field, which may be zero. A third selects a fixed mode for the safety node: it stays on the internal RC source, it ignores selector writes and it can never be gated off. The slice checks every requested selector code against its mask. A rejected code leaves the selector as it was and raises a sticky error. The reported enable follows the chosen parent, so a node only counts as running when its parent is running too. The divide field is presented as a ratio, which is the field value plus one.

Top module: `clksel_slice`

## Requirements
- R1: After reset, the selector holds code 1 (internal RC), the disable bit is 0, the divide field is 0, the error flag is 0 and the divide ratio is 1.
- R2: The selector is the 5-bit field at bits 28:24 of the control word. A write whose code is in the instance's allowed mask loads it in the clock edge of the write. The selector never holds a code outside the mask.
- R3: A write with a code outside the allowed mask leaves the selector unchanged and sets the error flag. This covers the reserved codes 5, 10 and 11 and every code from 17 to 31.
- R4: Bit 0 is a disable with inverted sense: writing 1 turns the output off and writing 0 turns it on. The bit reads back as written.
- R5: The divide field starts at bit 2 and is DIV_W bits wide. Written values are clipped to that width. The divide ratio output is the field value plus one. All bits outside the three fields read as 0.
- R6: The output is reported running only when all three hold: the selected source is valid, that source is enabled, and bit 0 is 0. Dropping either source indication stops it in the same cycle.
- R7: In the fixed safety mode, the selector stays on code 1 and bit 0 stays 0 whatever is written, and the error flag never rises.
- R8: Once set, the error flag stays set until reset. Later legal writes do not clear it.
- R9: A write whose selector code is rejected still updates the disable bit and the divide field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| src_enable | input | 17 | Running indication for each source code |
| src_valid | input | 17 | Exists indication for each source code |
| rd_data | output | 32 | Current control word |
| div_ratio | output | DIV_W+1 | Divide field plus one |
| clk_on | output | 1 | Resolved running state of this node |
| sel_err | output | 1 | Sticky flag for a rejected selector code |

## Verification
The bench builds three instances that share all their inputs, and checks every output of all three after each step.

- The first uses a 4-bit divide field and the broad source mask. It shows the clipping of an 8-bit divide value to 4 bits.
- The second uses an 8-bit field and a narrower mask without code 16. This brings within reach both the full 256 divide ratio and a code that one instance accepts while another rejects it.
- The third is the fixed safety variant with no divide field. Every write in the run is therefore also a test that it ignores selector and disable writes.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   localparam int NUM_SRC  = 17;
   localparam int SEL_W    = 5;
   localparam int SEL_LSB  = 24;
   localparam int DIV_LSB  = 2;
   localparam int GATE_BIT = 0;
   localparam int RC_SRC   = 1;
   localparam logic [NUM_SRC-1:0] RSVD_MASK = 17'h00C20;

   function automatic logic code_in(input logic [NUM_SRC-1:0] mask, input int code);
      logic [31:0] ext;
      ext = 32'(mask);
      return (code >= 0) && (code < 32) && ext[code];
   endfunction
endpackage

// File: rtl/clksel_src_check.sv
module clksel_src_check
   import clksel_pkg::*;
#(
   parameter logic [NUM_SRC-1:0] ALLOWED_MASK = 17'h1F35F
) (
   input  logic [SEL_W-1:0] req_sel,
   output logic             req_ok
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_code
      if (ALLOWED_MASK[i]) begin : g_allowed
         assign hit[i] = (req_sel == SEL_W'(i));
      end else begin : g_barred
         assign hit[i] = 1'b0;
      end
   end

   assign req_ok = |hit;
endmodule

// File: rtl/clksel_ctrl_reg.sv
module clksel_ctrl_reg
   import clksel_pkg::*;
#(
   parameter int DIV_W     = 4,
   parameter int DIV_RW    = 4,
   parameter bit LOCKED    = 1'b0,
   parameter int RESET_SRC = RC_SRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_gate,
   input  logic [DIV_RW-1:0] wr_div,
   input  logic              sel_ok,
   output logic [SEL_W-1:0]  sel_q,
   output logic              gate_q,
   output logic [DIV_RW-1:0] div_q,
   output logic              err_q
);
   logic unused_in;
   assign unused_in = ^{wr_sel, wr_gate, wr_div, sel_ok};

   if (LOCKED) begin : g_fixed
      assign sel_q  = SEL_W'(RESET_SRC);
      assign gate_q = 1'b0;
      assign err_q  = 1'b0;
   end else begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q  <= SEL_W'(RESET_SRC);
            gate_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (wr_en) begin
            gate_q <= wr_gate;
            if (sel_ok) sel_q <= wr_sel;
            else        err_q <= 1'b1;
         end
      end
   end

   if (DIV_W > 0) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     div_q <= '0;
         else if (wr_en) div_q <= wr_div;
      end
   end else begin : g_nodiv
      assign div_q = '0;
   end
endmodule

// File: rtl/clksel_status.sv
module clksel_status
   import clksel_pkg::*;
#(
   parameter logic [NUM_SRC-1:0] ALLOWED_MASK = 17'h1F35F
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic               gate,
   input  logic [NUM_SRC-1:0] src_enable,
   input  logic [NUM_SRC-1:0] src_valid,
   output logic               clk_on
);
   logic [NUM_SRC-1:0] live;
   logic unused_src;
   assign unused_src = ^{src_enable, src_valid};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_par
      if (ALLOWED_MASK[i]) begin : g_cand
         assign live[i] = (sel == SEL_W'(i)) & src_enable[i] & src_valid[i];
      end else begin : g_none
         assign live[i] = 1'b0;
      end
   end

   assign clk_on = (|live) & ~gate;
endmodule

// File: rtl/clksel_slice.sv
module clksel_slice
   import clksel_pkg::*;
#(
   parameter int                 DIV_W        = 4,
   parameter logic [NUM_SRC-1:0] ALLOWED_MASK = 17'h1F35F,
   parameter bit                 LOCKED       = 1'b0,
   parameter int                 RESET_SRC    = RC_SRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [31:0]        wr_data,
   input  logic [NUM_SRC-1:0] src_enable,
   input  logic [NUM_SRC-1:0] src_valid,
   output logic [31:0]        rd_data,
   output logic [DIV_W:0]     div_ratio,
   output logic               clk_on,
   output logic               sel_err
);
   localparam int DIV_RW = (DIV_W == 0) ? 1 : DIV_W;

   if (DIV_W < 0 || DIV_LSB + DIV_W > SEL_LSB) begin : g_bad_div
      $error("clksel_slice: divide field overlaps the selector");
   end
   if ((ALLOWED_MASK & RSVD_MASK) != '0) begin : g_bad_rsvd
      $error("clksel_slice: allowed mask names a reserved code");
   end
   if (!code_in(ALLOWED_MASK, RESET_SRC)) begin : g_bad_rst
      $error("clksel_slice: reset source not in allowed mask");
   end
   if (LOCKED && ALLOWED_MASK != (NUM_SRC'(1) << RESET_SRC)) begin : g_bad_lock
      $error("clksel_slice: fixed mode must allow only the reset source");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              gate_q;
   logic [DIV_RW-1:0] div_q;
   logic              sel_ok;
   logic unused_wr;
   assign unused_wr = ^wr_data;

   clksel_src_check #(.ALLOWED_MASK(ALLOWED_MASK)) u_check (
      .req_sel (wr_data[SEL_LSB +: SEL_W]),
      .req_ok  (sel_ok)
   );

   clksel_ctrl_reg #(
      .DIV_W(DIV_W), .DIV_RW(DIV_RW), .LOCKED(LOCKED), .RESET_SRC(RESET_SRC)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_data[SEL_LSB +: SEL_W]),
      .wr_gate (wr_data[GATE_BIT]),
      .wr_div  (wr_data[DIV_LSB +: DIV_RW]),
      .sel_ok  (sel_ok),
      .sel_q   (sel_q),
      .gate_q  (gate_q),
      .div_q   (div_q),
      .err_q   (sel_err)
   );

   clksel_status #(.ALLOWED_MASK(ALLOWED_MASK)) u_status (
      .sel        (sel_q),
      .gate       (gate_q),
      .src_enable (src_enable),
      .src_valid  (src_valid),
      .clk_on     (clk_on)
   );

   always_comb begin
      rd_data                      = '0;
      rd_data[SEL_LSB +: SEL_W]    = sel_q;
      rd_data[GATE_BIT]            = gate_q;
      if (DIV_W > 0)
         rd_data[DIV_LSB +: DIV_RW] = div_q;
   end

   if (DIV_W > 0) begin : g_ratio
      assign div_ratio = (DIV_W + 1)'(div_q) + (DIV_W + 1)'(1);
   end else begin : g_unity
      assign div_ratio = 1'b1;
   end
endmodule

// File: rtl/clksel_slice_chk.sv
module clksel_slice_chk
   import clksel_pkg::*;
#(
   parameter int                 DIV_W        = 4,
   parameter logic [NUM_SRC-1:0] ALLOWED_MASK = 17'h1F35F,
   parameter bit                 LOCKED       = 1'b0,
   parameter int                 RESET_SRC    = RC_SRC
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [31:0]        wr_data,
   input logic [NUM_SRC-1:0] src_enable,
   input logic [NUM_SRC-1:0] src_valid,
   input logic [31:0]        rd_data,
   input logic               clk_on,
   input logic               sel_err
);
   logic [31:0] am, rs, en_x, vl_x;
   logic [SEL_W-1:0] cur_sel, req_sel;
   assign am      = 32'(ALLOWED_MASK);
   assign rs      = 32'(RSVD_MASK);
   assign en_x    = 32'(src_enable);
   assign vl_x    = 32'(src_valid);
   assign cur_sel = rd_data[SEL_LSB +: SEL_W];
   assign req_sel = wr_data[SEL_LSB +: SEL_W];

   AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !LOCKED && am[req_sel]) |=> (cur_sel == $past(req_sel))); // R2
   AST_SEL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (am[cur_sel] && !rs[cur_sel])); // R2
   AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !LOCKED && !am[req_sel]) |=> (cur_sel == $past(cur_sel) && sel_err)); // R3
   AST_GATE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !LOCKED) |=> (rd_data[GATE_BIT] == $past(wr_data[GATE_BIT]))); // R4
   AST_ON_NEEDS_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_on |-> (en_x[cur_sel] && vl_x[cur_sel] && !rd_data[GATE_BIT])); // R6
   AST_FIXED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!LOCKED || (cur_sel == SEL_W'(RESET_SRC) && !rd_data[GATE_BIT] && !sel_err))); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |=> sel_err); // R8
endmodule

bind clksel_slice clksel_slice_chk #(
   .DIV_W(DIV_W), .ALLOWED_MASK(ALLOWED_MASK), .LOCKED(LOCKED), .RESET_SRC(RESET_SRC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .src_enable(src_enable), .src_valid(src_valid), .rd_data(rd_data),
   .clk_on(clk_on), .sel_err(sel_err)
);

// File: tb/tb_clksel_slice.sv
module tb_clksel_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [16:0] src_enable = '1;
   logic [16:0] src_valid = '1;

   always #5 clk = ~clk;

   localparam int DW [3] = '{4, 8, 0};
   localparam logic [2:0][16:0] MK = {17'h00002, 17'h0135F, 17'h1F35F};
   localparam logic [2:0] LK = 3'b100;

   logic [31:0] rd0, rd1, rd2;
   logic [4:0]  ra0;
   logic [8:0]  ra1;
   logic [0:0]  ra2;
   logic [2:0]  on_v, err_v;

   clksel_slice #(.DIV_W(4), .ALLOWED_MASK(17'h1F35F), .LOCKED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_enable(src_enable), .src_valid(src_valid), .rd_data(rd0),
      .div_ratio(ra0), .clk_on(on_v[0]), .sel_err(err_v[0]));
   clksel_slice #(.DIV_W(8), .ALLOWED_MASK(17'h0135F), .LOCKED(1'b0)) dut_w8 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_enable(src_enable), .src_valid(src_valid), .rd_data(rd1),
      .div_ratio(ra1), .clk_on(on_v[1]), .sel_err(err_v[1]));
   clksel_slice #(.DIV_W(0), .ALLOWED_MASK(17'h00002), .LOCKED(1'b1)) dut_safe (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_enable(src_enable), .src_valid(src_valid), .rd_data(rd2),
      .div_ratio(ra2), .clk_on(on_v[2]), .sel_err(err_v[2]));

   typedef struct packed {
      logic [2:0][31:0] w;
      logic [2:0][31:0] r;
      logic [2:0]       on;
      logic [2:0]       er;
   } exp_t;

   exp_t  exp_q [$];
   string tag_q [$];
   int    checks = 0;
   int    errors = 0;
   int    m_sel [3];
   int    m_div [3];
   bit    m_gate [3];
   bit    m_err [3];

   task automatic chk(input string tag, input string what, input int k,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, k, act, expv);
      end
   endtask

   // driver: applies one step, advances the requirement model, queues expectations
   task automatic step(input bit wr, input logic [31:0] data, input logic [16:0] en,
                       input logic [16:0] vld, input string tag);
      exp_t e;
      @(negedge clk); #1;
      wr_en = wr; wr_data = data; src_enable = en; src_valid = vld;
      @(posedge clk); #1;
      wr_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (wr && !LK[k]) begin
            int req;
            req = int'(data[28:24]);
            if (req < 17 && MK[k][req]) m_sel[k] = req;
            else m_err[k] = 1'b1;
            m_gate[k] = data[0];
         end
         if (wr) m_div[k] = int'((data >> 2) & ((32'd1 << DW[k]) - 1));
         e.w[k]  = (32'(m_sel[k]) << 24) | (32'(m_div[k]) << 2) | 32'(m_gate[k]);
         e.r[k]  = 32'(m_div[k] + 1);
         e.on[k] = vld[m_sel[k]] & en[m_sel[k]] & ~m_gate[k];
         e.er[k] = m_err[k];
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compares at the falling edge after each step
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         logic [31:0] aw [3];
         logic [31:0] ar [3];
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         aw[0] = rd0; aw[1] = rd1; aw[2] = rd2;
         ar[0] = 32'(ra0); ar[1] = 32'(ra1); ar[2] = 32'(ra2);
         for (int k = 0; k < 3; k++) begin
            chk(t, "rd_data", k, aw[k], e.w[k]);
            chk(t, "div_ratio", k, ar[k], e.r[k]);
            chk(t, "clk_on", k, 32'(on_v[k]), 32'(e.on[k]));
            chk(t, "sel_err", k, 32'(err_v[k]), 32'(e.er[k]));
         end
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         m_sel[k] = 1; m_div[k] = 0; m_gate[k] = 1'b0; m_err[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 32'h0, '1, '1, "R1 reset state");
      step(1'b1, (32'd9 << 24) | (32'd5 << 2), '1, '1, "R2 R5 legal select and divide");
      step(1'b1, (32'd5 << 24) | (32'd3 << 2), '1, '1, "R3 R9 reserved code 5");
      step(1'b1, (32'd8 << 24) | (32'hFF << 2), '1, '1, "R5 R8 clip divide, error sticky");
      step(1'b1, (32'd16 << 24), '1, '1, "R2 R3 code 16 per-instance mask");
      step(1'b1, (32'd20 << 24) | (32'd1 << 2), '1, '1, "R3 code above range");
      step(1'b1, (32'd11 << 24) | 32'd1, '1, '1, "R3 R9 reserved code 11 with disable");
      step(1'b1, (32'd8 << 24) | 32'd1, '1, '1, "R4 R7 disable bit set");
      step(1'b1, (32'd1 << 24) | 32'h8080_0002, '1, '1, "R4 R5 enable, stray bits read zero");
      step(1'b0, 32'h0, 17'h1FFFD, '1, "R6 parent not running");
      step(1'b0, 32'h0, '1, 17'h1FFFD, "R6 parent not valid");
      step(1'b0, 32'h0, 17'h00002, 17'h00002, "R6 only parent alive");
      step(1'b1, (32'd6 << 24) | (32'd2 << 2), '1, '1, "R7 R8 legal write after error");
      step(1'b1, (32'd10 << 24), '1, '1, "R3 reserved code 10");
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule